// File: doc/BRIEF.md
# Fixed-Priority Address-Decoding Bus Crossbar

This block joins three bus masters to five memory-mapped slaves. Master 0 is a debug loader, master 1 is a processor data port and master 2 is a processor instruction port. Each master presents read and write strobes, an address, write data and byte enables. The crossbar compares every master address with the window of each slave. A slave window is set by a base and a mask parameter. The crossbar then forwards the request to the matching slave and raises the master's grant in the same cycle.

When more than one master addresses the same slave, the lower master index wins. Masters that address different slaves are served in parallel. A master that loses keeps its request stable and retries until it is granted. Slaves return read data one cycle after they see a read strobe.

A small response tracker per master records which slave served the granted read. In the next cycle it returns that slave's data with a one-cycle valid pulse. The tracker has three states:
- RSP_IDLE: no response is due.
- RSP_FROM_SLAVE: return the recorded slave's data.
- RSP_ZERO: return zero for an address that hit no window.

A granted read moves the tracker from any state to RSP_FROM_SLAVE or RSP_ZERO. A cycle without a granted read moves it back to RSP_IDLE.

Top module: `prio_xbar`

## Requirements
- R1: Slave s is selected when (address & ~MASK[s]) == BASE[s]. Slave s uses bits [32s+31:32s] of the packed parameters. The default windows are: slave 0 at 0x00000000–0x00000FFF, slave 1 at 0x00008000–0x00008FFF, slave 2 at 0x00010000–0x00010FFF, slave 3 at 0x00020000–0x00020FFF, and slave 4 at 0x00030000–0x00030003.
- R2: When several masters request the same slave in one cycle, the lowest-indexed master is granted. Each other requester on that slave sees its grant low in that cycle.
- R3: Masters whose addresses hit different slaves are all granted in the same cycle.
- R4: Each slave receives the read strobe, write strobe, address, write data and byte enables of the master granted to it. A slave with no granted master sees both strobes low.
- R5: After a granted read, the master's read-valid is 1 in the next cycle only. Its read data then equals the data that the addressed slave returns in that cycle. No other master's read-valid rises.
- R6: A request whose address hits no window is granted in the same cycle. It reaches no slave. If it is a read, it returns read-valid with data 0x00000000 in the next cycle.
- R7: A granted write produces no read-valid in the next cycle.
- R8: The reset is active-low and synchronous. A master with neither strobe set has its grant low. In the first cycle after reset is released, no read-valid is asserted, even if a read was presented during reset.
- R9: The slave 4 window spans exactly one 32-bit word. Address 0x00030004 hits no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_rd | input | NM | Read strobe per master |
| m_wr | input | NM | Write strobe per master |
| m_addr | input | NM x AW | Address per master |
| m_wdata | input | NM x DW | Write data per master |
| m_be | input | NM x DW/8 | Byte enables per master |
| m_gnt | output | NM | Grant per master, same cycle |
| m_rvalid | output | NM | Read-response valid per master |
| m_rdata | output | NM x DW | Read data per master |
| s_rd | output | NS | Read strobe per slave |
| s_wr | output | NS | Write strobe per slave |
| s_addr | output | NS x AW | Address per slave |
| s_wdata | output | NS x DW | Write data per slave |
| s_be | output | NS x DW/8 | Byte enables per slave |
| s_rdata | input | NS x DW | Read data per slave, one cycle after its read strobe |

## Verification
The routing path has no registers, so a decode or arbitration fault shows at once. In the request cycle itself, the wrong grant bit or the wrong slave strobe and address appears. A corrupted tracker state or recorded slave index shows exactly one cycle later. The symptoms are a missing or extra read-valid pulse, or data taken from the wrong slave or not forced to zero. Every scenario checks the slave-side ports in the request cycle and the response ports in the following cycle, so a fault is caught within two cycles of the stimulus that exposes it.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE       = 2'd0,
        RSP_FROM_SLAVE = 2'd1,
        RSP_ZERO       = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/pxb_decode.sv
module pxb_decode #(
    parameter int              NS   = 5,
    parameter int              AW   = 32,
    parameter logic [NS*AW-1:0] BASE = '0,
    parameter logic [NS*AW-1:0] MASK = '0,
    localparam int             SIW  = (NS > 1) ? $clog2(NS) : 1
)(
    input  logic [AW-1:0]  addr,
    output logic           hit,
    output logic [SIW-1:0] idx
);
    // Lowest-numbered matching window wins if windows overlap.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if ((addr & ~MASK[s*AW +: AW]) == BASE[s*AW +: AW]) begin
                hit = 1'b1;
                idx = SIW'(s);
            end
        end
    end
endmodule

// File: rtl/pxb_arbiter.sv
module pxb_arbiter #(
    parameter int NM = 3
)(
    input  logic [NM-1:0] req,
    output logic [NM-1:0] win
);
    // Fixed priority: index 0 highest.
    always_comb begin
        win = '0;
        for (int m = NM - 1; m >= 0; m--) begin
            if (req[m]) begin
                win    = '0;
                win[m] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pxb_rsp_track.sv
module pxb_rsp_track
    import pxb_pkg::*;
#(
    parameter int NS  = 5,
    parameter int DW  = 32,
    localparam int SIW = (NS > 1) ? $clog2(NS) : 1
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_rd,
    input  logic                 hit,
    input  logic [SIW-1:0]       idx,
    input  logic [NS-1:0][DW-1:0] s_rdata,
    output logic                 rvalid,
    output logic [DW-1:0]        rdata
);
    rsp_state_e     state, state_nx;
    logic [SIW-1:0] src, src_nx;

    always_comb begin
        state_nx = RSP_IDLE;
        src_nx   = src;
        if (take_rd) begin
            state_nx = hit ? RSP_FROM_SLAVE : RSP_ZERO;
            src_nx   = idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RSP_IDLE;
            src   <= '0;
        end else begin
            state <= state_nx;
            src   <= src_nx;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state)
            RSP_IDLE: ;
            RSP_FROM_SLAVE: begin
                rvalid = 1'b1;
                rdata  = s_rdata[src];
            end
            RSP_ZERO: rvalid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar #(
    parameter int               NM   = 3,
    parameter int               NS   = 5,
    parameter int               AW   = 32,
    parameter int               DW   = 32,
    parameter logic [NS*AW-1:0] BASE = {32'h0003_0000, 32'h0002_0000, 32'h0001_0000,
                                        32'h0000_8000, 32'h0000_0000},
    parameter logic [NS*AW-1:0] MASK = {32'h0000_0003, 32'h0000_0fff, 32'h0000_0fff,
                                        32'h0000_0fff, 32'h0000_0fff},
    localparam int              BW   = DW / 8,
    localparam int              SIW  = (NS > 1) ? $clog2(NS) : 1
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          m_rd,
    input  logic [NM-1:0]          m_wr,
    input  logic [NM-1:0][AW-1:0]  m_addr,
    input  logic [NM-1:0][DW-1:0]  m_wdata,
    input  logic [NM-1:0][BW-1:0]  m_be,
    output logic [NM-1:0]          m_gnt,
    output logic [NM-1:0]          m_rvalid,
    output logic [NM-1:0][DW-1:0]  m_rdata,
    output logic [NS-1:0]          s_rd,
    output logic [NS-1:0]          s_wr,
    output logic [NS-1:0][AW-1:0]  s_addr,
    output logic [NS-1:0][DW-1:0]  s_wdata,
    output logic [NS-1:0][BW-1:0]  s_be,
    input  logic [NS-1:0][DW-1:0]  s_rdata
);
    logic [NM-1:0]          hit;
    logic [NM-1:0][SIW-1:0] idx;
    logic [NM-1:0]          active;
    logic [NS-1:0][NM-1:0]  req_to;
    logic [NS-1:0][NM-1:0]  win;

    for (genvar m = 0; m < NM; m++) begin : g_mst
        assign active[m] = m_rd[m] | m_wr[m];

        pxb_decode #(.NS(NS), .AW(AW), .BASE(BASE), .MASK(MASK)) u_dec (
            .addr (m_addr[m]),
            .hit  (hit[m]),
            .idx  (idx[m])
        );

        for (genvar s = 0; s < NS; s++) begin : g_req
            assign req_to[s][m] = active[m] & hit[m] & (idx[m] == SIW'(s));
        end

        assign m_gnt[m] = active[m] & (~hit[m] | win[idx[m]][m]);

        pxb_rsp_track #(.NS(NS), .DW(DW)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .take_rd (m_gnt[m] & m_rd[m]),
            .hit     (hit[m]),
            .idx     (idx[m]),
            .s_rdata (s_rdata),
            .rvalid  (m_rvalid[m]),
            .rdata   (m_rdata[m])
        );
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        pxb_arbiter #(.NM(NM)) u_arb (
            .req (req_to[s]),
            .win (win[s])
        );

        always_comb begin
            s_rd[s]    = 1'b0;
            s_wr[s]    = 1'b0;
            s_addr[s]  = '0;
            s_wdata[s] = '0;
            s_be[s]    = '0;
            for (int m = 0; m < NM; m++) begin
                if (win[s][m]) begin
                    s_rd[s]    = m_rd[m];
                    s_wr[s]    = m_wr[m];
                    s_addr[s]  = m_addr[m];
                    s_wdata[s] = m_wdata[m];
                    s_be[s]    = m_be[m];
                end
            end
        end
    end
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
    parameter int NM = 3
)(
    input logic          clk,
    input logic          rst_n,
    input logic [NM-1:0] m_rd,
    input logic [NM-1:0] m_wr,
    input logic [NM-1:0] m_gnt,
    input logic [NM-1:0] m_rvalid
);
    // R2: the top-priority master is never refused.
    assert_top_master_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd[0] || m_wr[0]) |-> m_gnt[0]);

    // R8: nothing pending right after reset.
    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (m_rvalid == '0));

    for (genvar m = 0; m < NM; m++) begin : g_m
        // R5
        assert_read_answered_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (m_gnt[m] && m_rd[m]) |=> m_rvalid[m]);
        // R7
        assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(m_gnt[m] && m_rd[m]) |=> !m_rvalid[m]);
        // R8
        assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(m_rd[m] || m_wr[m]) |-> !m_gnt[m]);
    end
endmodule

bind prio_xbar pxb_checker #(.NM(NM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_rd     (m_rd),
    .m_wr     (m_wr),
    .m_gnt    (m_gnt),
    .m_rvalid (m_rvalid)
);

// File: tb/sim_prio_xbar.sv
module sim_prio_xbar;
    localparam int NM = 3;
    localparam int NS = 5;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NM-1:0]        m_rd, m_wr, m_gnt, m_rvalid;
    logic [NM-1:0][31:0]  m_addr, m_wdata, m_rdata;
    logic [NM-1:0][3:0]   m_be;
    logic [NS-1:0]        s_rd, s_wr;
    logic [NS-1:0][31:0]  s_addr, s_wdata, s_rdata;
    logic [NS-1:0][3:0]   s_be;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    prio_xbar u0 (
        .clk(clk), .rst_n(rst_n),
        .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
        .m_gnt(m_gnt), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .s_rd(s_rd), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_be(s_be),
        .s_rdata(s_rdata)
    );

    function automatic logic [31:0] pat(int s, logic [31:0] a);
        return 32'hC0DE_0000 | (32'(s) << 8) | {24'h0, a[7:0]};
    endfunction

    // Slave models: registered read data, one cycle after the read strobe.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++)
            if (s_rd[s]) s_rdata[s] <= pat(s, s_addr[s]);
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        m_rd = '0; m_wr = '0; m_addr = '0; m_wdata = '0; m_be = '0;
    endtask

    task automatic t_reset();
        idle_all();
        rst_n = 1'b0;
        m_rd[1] = 1'b1; m_addr[1] = 32'h0001_0020;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_all();
        #1;
        chk("R8 idle grant", 32'(m_gnt), 0);
        @(posedge clk); @(negedge clk);
        chk("R8 rvalid after release", 32'(m_rvalid), 0);
    endtask

    task automatic t_decode(logic [31:0] a, bit hit, int slv);
        @(negedge clk);
        idle_all();
        m_rd[1] = 1'b1; m_addr[1] = a;
        #1;
        chk("R6 grant", 32'(m_gnt), 32'b010);
        chk("R1 slave strobe", 32'(s_rd), hit ? (32'h1 << slv) : 0);
        if (hit) chk("R4 slave addr", s_addr[slv], a);
        @(posedge clk); @(negedge clk);
        idle_all();
        chk("R5 rvalid", 32'(m_rvalid), 32'b010);
        chk(hit ? "R5 rdata" : "R6 zero data", m_rdata[1], hit ? pat(slv, a) : 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        idle_all();
        for (int m = 0; m < NM; m++) begin
            m_rd[m] = 1'b1; m_addr[m] = 32'h0001_0040 + 32'(m * 4);
        end
        #1;
        chk("R2 three-way grant", 32'(m_gnt), 32'b001);
        chk("R2 winner addr", s_addr[2], 32'h0001_0040);
        @(posedge clk); @(negedge clk);
        m_rd[0] = 1'b0;
        chk("R5 only winner valid", 32'(m_rvalid), 32'b001);
        chk("R5 winner data", m_rdata[0], pat(2, 32'h0001_0040));
        #1;
        chk("R2 data over instr", 32'(m_gnt), 32'b010);
        chk("R2 second winner addr", s_addr[2], 32'h0001_0044);
        @(posedge clk); @(negedge clk);
        m_rd[1] = 1'b0;
        chk("R5 second data", m_rdata[1], pat(2, 32'h0001_0044));
        #1;
        chk("R2 last grant", 32'(m_gnt), 32'b100);
        @(posedge clk); @(negedge clk);
        idle_all();
        chk("R5 last valid", 32'(m_rvalid), 32'b100);
        chk("R5 last data", m_rdata[2], pat(2, 32'h0001_0048));
    endtask

    task automatic t_parallel();
        @(negedge clk);
        idle_all();
        m_rd = 3'b111;
        m_addr[0] = 32'h0002_0010;
        m_addr[1] = 32'h0001_0014;
        m_addr[2] = 32'h0000_0018;
        #1;
        chk("R3 all granted", 32'(m_gnt), 32'b111);
        chk("R3 slave strobes", 32'(s_rd), 32'b01101);
        @(posedge clk); @(negedge clk);
        idle_all();
        chk("R3 m0 data", m_rdata[0], pat(3, 32'h0002_0010));
        chk("R3 m1 data", m_rdata[1], pat(2, 32'h0001_0014));
        chk("R3 m2 data", m_rdata[2], pat(0, 32'h0000_0018));
    endtask

    task automatic t_write();
        @(negedge clk);
        idle_all();
        m_wr[1] = 1'b1; m_addr[1] = 32'h0003_0000;
        m_wdata[1] = 32'h1234_5678; m_be[1] = 4'b0101;
        #1;
        chk("R4 write strobe", 32'(s_wr), 32'b10000);
        chk("R4 wdata", s_wdata[4], 32'h1234_5678);
        chk("R4 be", 32'(s_be[4]), 32'b0101);
        chk("R7 write grant", 32'(m_gnt), 32'b010);
        @(posedge clk); @(negedge clk);
        idle_all();
        chk("R7 no valid after write", 32'(m_rvalid), 0);
    endtask

    task automatic t_unmapped_write();
        @(negedge clk);
        idle_all();
        m_wr[0] = 1'b1; m_addr[0] = 32'h0004_0000; m_wdata[0] = 32'hDEAD_BEEF;
        #1;
        chk("R6 unmapped write grant", 32'(m_gnt), 32'b001);
        chk("R6 unmapped write dropped", 32'(s_wr), 0);
        @(posedge clk); @(negedge clk);
        idle_all();
        chk("R6 no valid", 32'(m_rvalid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_decode(32'h0000_0010, 1'b1, 0);
        t_decode(32'h0000_0FFC, 1'b1, 0);
        t_decode(32'h0000_1000, 1'b0, 0);
        t_decode(32'h0000_8024, 1'b1, 1);
        t_decode(32'h0001_0ABC, 1'b1, 2);
        t_decode(32'h0002_0F00, 1'b1, 3);
        t_decode(32'h0003_0000, 1'b1, 4);
        t_decode(32'h0003_0004, 1'b0, 0);   // R9
        t_priority();
        t_parallel();
        t_write();
        t_unmapped_write();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule